// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between a memory controller's command scheduler and the SDRAM command pins. The scheduler offers one command at a time on a valid/ready handshake. The guard holds ready low until every minimum spacing that applies to that command has elapsed since the command that started it. It then forwards the accepted command to the pins one clock later. One shared bank-timing context is tracked. Address mapping, data capture, refresh policy and power-up sequencing are handled elsewhere.

The spacings come from a 32-bit timing register inside the block. It resets to a fixed value, and software can write and read it. Each field holds an offset-encoded cycle count. If a field holds a reserved code, the interval falls back to its largest encodable length and a sticky error flag is raised. The CAS latency field is deferred: a value written there takes effect only on a rising edge of a separate program input. For every read, the guard pulses a flag in the clock in which the first read data is due at the pins.

Top module: `sdram_cmd_guard`

## Requirements
- R1: The timing register reads 32'h2A733225 after reset. A write stores the write data, except bits 31, 19 and 15, which always read as zero. Readback shows the new value in the clock after the write edge.
- R2: Bits 27:24 hold the refresh cycle time. Code n (1..15) means n+1 clocks. An ACT or RFSH is not accepted earlier than that many clocks after an accepted RFSH.
- R3: Bits 23:20 hold the activate-to-precharge time, with the same n+1 encoding. A PRE is not accepted earlier than that many clocks after an accepted ACT.
- R4: Bits 18:16 hold the precharge-to-activate time. Code n (1..7) means n clocks. An ACT is not accepted earlier than that many clocks after an accepted PRE.
- R5: Bits 14:12 hold the activate-to-column time, with the same n-clock encoding. A READ or WRITE is not accepted earlier than that many clocks after an accepted ACT.
- R6: Bits 30:28 hold the CAS latency. Code 2..7 means that many clocks. The field is committed only on a clock where the program input is 1 and was 0 on the clock before. Reset commits latency 2. rd_data_expected is high exactly committed-latency clocks after the READ appears on out_cmd.
- R7: Reads accepted in consecutive or overlapping windows each produce their own single-clock rd_data_expected pulse.
- R8: A reserved code (0 in bits 27:24, 23:20, 18:16 or 14:12) makes that interval its maximum: 16, 16, 7 or 7 clocks. A commit of CAS code 0 or 1 gives latency 7. Any of these sets config_error one clock later, and config_error then stays high until reset.
- R9: Command codes are NOP=0, ACT=1, READ=2, WRITE=3, PRE=4, RFSH=5; codes 6 and 7 act as NOP. A NOP is always ready and restarts no interval. An accepted command appears on out_cmd in the next clock. out_cmd is NOP in every other clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 32 | Timing register write data |
| cfg_rdata | output | 32 | Timing register readback |
| cfg_prog | input | 1 | Program input; its rising edge commits the CAS latency |
| cmd_valid | input | 1 | Scheduler offers a command |
| cmd_kind | input | 3 | Offered command code |
| cmd_ready | output | 1 | Offered command may issue this clock |
| out_cmd | output | 3 | Command driven to the SDRAM pins |
| rd_data_expected | output | 1 | First read data due this clock |
| config_error | output | 1 | Sticky flag for a reserved timing code |

## Verification
cmd_ready is combinational and is due in the same clock as the offered command. out_cmd follows an acceptance by one clock. rd_data_expected follows it by one clock plus the latency committed at the acceptance edge. config_error follows the edge at which a reserved code was present by one clock. The bench updates its reference model at each rising edge, in the same order the design applies the changes: acceptances first, then the latency commit, then the register write. It compares every output shortly after the falling edge, so each result is checked in exactly the clock in which it is due.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

   typedef enum logic [2:0] {
      CMD_NOP   = 3'd0,
      CMD_ACT   = 3'd1,
      CMD_READ  = 3'd2,
      CMD_WRITE = 3'd3,
      CMD_PRE   = 3'd4,
      CMD_RFSH  = 3'd5
   } cmd_e;

   // interval slots
   localparam int GAP_RC    = 0;
   localparam int GAP_RAS   = 1;
   localparam int GAP_RP    = 2;
   localparam int GAP_RCD   = 3;
   localparam int GAP_COUNT = 4;

   // field positions inside the timing register
   localparam int CAS_LSB = 28;
   localparam int RC_LSB  = 24;
   localparam int RAS_LSB = 20;
   localparam int RP_LSB  = 16;
   localparam int RCD_LSB = 12;
   localparam logic [31:0] RSVD_MASK = 32'h8008_8000;

   // 4-bit field, n+1 clocks, reserved 0 -> 16
   function automatic logic [4:0] decode_wide(input logic [3:0] code);
      return (code == 4'd0) ? 5'd16 : {1'b0, code} + 5'd1;
   endfunction

   // 3-bit field, n clocks, reserved 0 -> 7
   function automatic logic [4:0] decode_narrow(input logic [2:0] code);
      return (code == 3'd0) ? 5'd7 : {2'b00, code};
   endfunction

   // latency field, codes 0/1 reserved -> 7
   function automatic logic [4:0] decode_cas(input logic [2:0] code);
      return (code < 3'd2) ? 5'd7 : {2'b00, code};
   endfunction

endpackage

// File: rtl/sdram_timing_regs.sv
module sdram_timing_regs
   import sdram_guard_pkg::*;
#(
   parameter logic [31:0] RESET_VAL = 32'h2A73_3225,
   parameter int          LEN_W     = 5,
   parameter int          LAT_W     = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [31:0]                       wr_data,
   input  logic                              prog,
   output logic [31:0]                       rd_data,
   output logic [GAP_COUNT-1:0][LEN_W-1:0]   gap_len,
   output logic [LAT_W-1:0]                  cas_lat,
   output logic                              cfg_err
);

   localparam logic [31:0] RESET_STORED = RESET_VAL & ~RSVD_MASK;
   localparam logic [2:0]  RESET_CAS    = RESET_VAL[CAS_LSB +: 3];

   logic [31:0]      timing_q;
   logic             prog_q;
   logic [LAT_W-1:0] lat_q;
   logic             err_q;

   logic [2:0] cas_code;
   logic [3:0] rc_code;
   logic [3:0] ras_code;
   logic [2:0] rp_code;
   logic [2:0] rcd_code;
   logic       commit;
   logic       field_rsvd;
   logic       cas_rsvd;

   initial begin
      assert (LEN_W >= 5) else $error("LEN_W must hold 16");
      assert (LAT_W >= 3) else $error("LAT_W must hold 7");
   end

   always_comb begin
      cas_code   = timing_q[CAS_LSB +: 3];
      rc_code    = timing_q[RC_LSB  +: 4];
      ras_code   = timing_q[RAS_LSB +: 4];
      rp_code    = timing_q[RP_LSB  +: 3];
      rcd_code   = timing_q[RCD_LSB +: 3];
      commit     = prog & ~prog_q;
      cas_rsvd   = (cas_code < 3'd2);
      field_rsvd = (rc_code == 4'd0) | (ras_code == 4'd0) |
                   (rp_code == 3'd0) | (rcd_code == 3'd0);
   end

   always_comb begin
      gap_len[GAP_RC]  = LEN_W'(decode_wide(rc_code));
      gap_len[GAP_RAS] = LEN_W'(decode_wide(ras_code));
      gap_len[GAP_RP]  = LEN_W'(decode_narrow(rp_code));
      gap_len[GAP_RCD] = LEN_W'(decode_narrow(rcd_code));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         timing_q <= RESET_STORED;
         prog_q   <= 1'b0;
         lat_q    <= LAT_W'(decode_cas(RESET_CAS));
         err_q    <= 1'b0;
      end else begin
         prog_q <= prog;
         if (commit) lat_q <= LAT_W'(decode_cas(cas_code));
         err_q <= err_q | field_rsvd | (commit & cas_rsvd);
         if (wr_en) timing_q <= wr_data & ~RSVD_MASK;
      end
   end

   assign rd_data = timing_q;
   assign cas_lat = lat_q;
   assign cfg_err = err_q;

endmodule

// File: rtl/sdram_gap_counter.sv
module sdram_gap_counter #(
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   output logic             expired
);

   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= len - LEN_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - LEN_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_cas_tracker.sv
module sdram_cas_tracker #(
   parameter int CL_MAX = 7,
   parameter int LAT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [LAT_W-1:0] lat,
   output logic             pulse
);

   localparam int SR_W = CL_MAX + 1;

   logic [SR_W-1:0] sr_q;
   logic [SR_W-1:0] inject;

   initial begin
      assert (CL_MAX >= 7) else $error("CL_MAX must cover latency 7");
   end

   always_comb begin
      inject = fire ? (SR_W'(1) << lat) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {1'b0, sr_q[SR_W-1:1]} | inject;
   end

   assign pulse = sr_q[0];

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
   import sdram_guard_pkg::*;
#(
   parameter logic [31:0] RESET_VAL = 32'h2A73_3225,
   parameter int          LEN_W     = 5,
   parameter int          LAT_W     = 3,
   parameter int          CL_MAX    = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic        cfg_prog,
   input  logic        cmd_valid,
   input  logic [2:0]  cmd_kind,
   output logic        cmd_ready,
   output logic [2:0]  out_cmd,
   output logic        rd_data_expected,
   output logic        config_error
);

   logic [GAP_COUNT-1:0][LEN_W-1:0] gap_len;
   logic [GAP_COUNT-1:0]            gap_load;
   logic [GAP_COUNT-1:0]            gap_done;
   logic [LAT_W-1:0]                cas_lat;
   logic                            accept;
   logic [2:0]                      out_q;

   sdram_timing_regs #(
      .RESET_VAL (RESET_VAL),
      .LEN_W     (LEN_W),
      .LAT_W     (LAT_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_data (cfg_wdata),
      .prog    (cfg_prog),
      .rd_data (cfg_rdata),
      .gap_len (gap_len),
      .cas_lat (cas_lat),
      .cfg_err (config_error)
   );

   assign accept = cmd_valid & cmd_ready;

   always_comb begin
      gap_load          = '0;
      gap_load[GAP_RC]  = accept & (cmd_kind == CMD_RFSH);
      gap_load[GAP_RAS] = accept & (cmd_kind == CMD_ACT);
      gap_load[GAP_RP]  = accept & (cmd_kind == CMD_PRE);
      gap_load[GAP_RCD] = accept & (cmd_kind == CMD_ACT);
   end

   for (genvar g = 0; g < GAP_COUNT; g++) begin : g_gap
      sdram_gap_counter #(.LEN_W(LEN_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (gap_load[g]),
         .len     (gap_len[g]),
         .expired (gap_done[g])
      );
   end

   always_comb begin
      case (cmd_kind)
         CMD_ACT:   cmd_ready = gap_done[GAP_RC] & gap_done[GAP_RP];
         CMD_READ,
         CMD_WRITE: cmd_ready = gap_done[GAP_RCD];
         CMD_PRE:   cmd_ready = gap_done[GAP_RAS];
         CMD_RFSH:  cmd_ready = gap_done[GAP_RC];
         default:   cmd_ready = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      out_q <= CMD_NOP;
      else if (accept && cmd_kind <= CMD_RFSH) out_q <= cmd_kind;
      else                             out_q <= CMD_NOP;
   end
   assign out_cmd = out_q;

   sdram_cas_tracker #(
      .CL_MAX (CL_MAX),
      .LAT_W  (LAT_W)
   ) u_cas (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (accept & (cmd_kind == CMD_READ)),
      .lat   (cas_lat),
      .pulse (rd_data_expected)
   );

endmodule

// File: rtl/sdram_cmd_guard_chk.sv
module sdram_cmd_guard_chk
   import sdram_guard_pkg::*;
#(
   parameter int LEN_W = 5,
   parameter int LAT_W = 3
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            cmd_valid,
   input logic [2:0]                      cmd_kind,
   input logic                            cmd_ready,
   input logic [2:0]                      out_cmd,
   input logic                            rd_data_expected,
   input logic                            config_error,
   input logic [GAP_COUNT-1:0][LEN_W-1:0] gap_len,
   input logic [LAT_W-1:0]                cas_lat
);

   logic       acc;
   logic [5:0] since_act;
   logic [5:0] since_rfsh;
   logic [5:0] ras_need;
   logic [5:0] rcd_need;
   logic [5:0] rc_need;

   assign acc = cmd_valid & cmd_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act  <= 6'd63;
         since_rfsh <= 6'd63;
         ras_need   <= '0;
         rcd_need   <= '0;
         rc_need    <= '0;
      end else begin
         if (acc && cmd_kind == CMD_ACT) begin
            since_act <= 6'd1;
            ras_need  <= 6'(gap_len[GAP_RAS]);
            rcd_need  <= 6'(gap_len[GAP_RCD]);
         end else if (since_act != 6'd63) begin
            since_act <= since_act + 6'd1;
         end
         if (acc && cmd_kind == CMD_RFSH) begin
            since_rfsh <= 6'd1;
            rc_need    <= 6'(gap_len[GAP_RC]);
         end else if (since_rfsh != 6'd63) begin
            since_rfsh <= since_rfsh + 6'd1;
         end
      end
   end

   AST_RC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (cmd_kind == CMD_ACT || cmd_kind == CMD_RFSH) |-> since_rfsh >= rc_need); // R2
   AST_RAS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cmd_kind == CMD_PRE |-> since_act >= ras_need); // R3
   AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (cmd_kind == CMD_READ || cmd_kind == CMD_WRITE) |-> since_act >= rcd_need); // R5
   AST_CL2_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cmd_kind == CMD_READ && cas_lat == 3'd2 |-> ##3 rd_data_expected); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      config_error |=> config_error); // R8
   AST_NOP_READY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_kind == CMD_NOP |-> cmd_ready); // R9
   AST_PIN_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cmd_kind == CMD_PRE |=> out_cmd == CMD_PRE); // R9

endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk #(.LEN_W(LEN_W), .LAT_W(LAT_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cmd_valid        (cmd_valid),
   .cmd_kind         (cmd_kind),
   .cmd_ready        (cmd_ready),
   .out_cmd          (out_cmd),
   .rd_data_expected (rd_data_expected),
   .config_error     (config_error),
   .gap_len          (gap_len),
   .cas_lat          (cas_lat)
);

// File: tb/sdram_cmd_guard_tb.sv
module sdram_cmd_guard_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        cfg_prog = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_kind = '0;
   logic        cmd_ready;
   logic [2:0]  out_cmd;
   logic        rd_data_expected;
   logic        config_error;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference model state
   int          cyc;
   int          d_rc, d_ras, d_rp, d_rcd;
   int          cl_m;
   bit          err_m, prog_prev;
   logic [31:0] reg_m;
   logic [2:0]  exp_out;
   bit [63:0]   exp_pulse;

   localparam logic [31:0] MASK = 32'h8008_8000;

   sdram_cmd_guard u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cfg_prog(cfg_prog), .cmd_valid(cmd_valid),
      .cmd_kind(cmd_kind), .cmd_ready(cmd_ready), .out_cmd(out_cmd),
      .rd_data_expected(rd_data_expected), .config_error(config_error)
   );

   always #4 clk = ~clk;

   function automatic int n_rc(input logic [31:0] r);
      return (r[27:24] == 0) ? 16 : int'(r[27:24]) + 1;
   endfunction
   function automatic int n_ras(input logic [31:0] r);
      return (r[23:20] == 0) ? 16 : int'(r[23:20]) + 1;
   endfunction
   function automatic int n_rp(input logic [31:0] r);
      return (r[18:16] == 0) ? 7 : int'(r[18:16]);
   endfunction
   function automatic int n_rcd(input logic [31:0] r);
      return (r[14:12] == 0) ? 7 : int'(r[14:12]);
   endfunction
   function automatic int n_cas(input logic [2:0] c);
      return (c < 2) ? 7 : int'(c);
   endfunction
   function automatic bit any_rsvd(input logic [31:0] r);
      return r[27:24] == 0 || r[23:20] == 0 || r[18:16] == 0 || r[14:12] == 0;
   endfunction

   function automatic bit exp_ready(input logic [2:0] k);
      case (k)
         3'd1:      return cyc >= d_rc && cyc >= d_rp;
         3'd2, 3'd3: return cyc >= d_rcd;
         3'd4:      return cyc >= d_ras;
         3'd5:      return cyc >= d_rc;
         default:   return 1'b1;
      endcase
   endfunction

   function automatic string ready_tag(input logic [2:0] k);
      case (k)
         3'd1:      return "R2 R4 R8 ready for ACT";
         3'd2, 3'd3: return "R5 R8 ready for READ/WRITE";
         3'd4:      return "R3 R8 ready for PRE";
         3'd5:      return "R2 R8 ready for RFSH";
         default:   return "R9 ready for NOP";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s at cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
      end
   endtask

   // one clock: check at negedge+1, update model at posedge, return at next negedge
   task automatic step(output bit acc);
      bit er;
      #1;
      er = exp_ready(cmd_kind);
      chk(cmd_ready == er, ready_tag(cmd_kind), 32'(cmd_ready), 32'(er));
      chk(out_cmd == exp_out, "R9 out_cmd", 32'(out_cmd), 32'(exp_out));
      chk(rd_data_expected == exp_pulse[cyc % 64], "R6 R7 rd_data_expected",
          32'(rd_data_expected), 32'(exp_pulse[cyc % 64]));
      exp_pulse[cyc % 64] = 1'b0;
      chk(config_error == err_m, "R8 config_error", 32'(config_error), 32'(err_m));
      chk(cfg_rdata == (reg_m & ~MASK), "R1 readback", cfg_rdata, reg_m & ~MASK);
      acc = cmd_valid && cmd_ready;
      @(posedge clk);
      exp_out = 3'd0;
      if (acc) begin
         if (cmd_kind <= 3'd5) exp_out = cmd_kind;
         case (cmd_kind)
            3'd1: begin d_ras = cyc + n_ras(reg_m); d_rcd = cyc + n_rcd(reg_m); end
            3'd2: exp_pulse[(cyc + 1 + cl_m) % 64] = 1'b1;
            3'd4: d_rp = cyc + n_rp(reg_m);
            3'd5: d_rc = cyc + n_rc(reg_m);
            default: ;
         endcase
      end
      if (any_rsvd(reg_m)) err_m = 1'b1;
      if (cfg_prog && !prog_prev) begin
         cl_m = n_cas(reg_m[30:28]);
         if (reg_m[30:28] < 2) err_m = 1'b1;
      end
      prog_prev = cfg_prog;
      if (cfg_we) reg_m = cfg_wdata & ~MASK;
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      bit a;
      repeat (n) step(a);
   endtask

   task automatic issue(input logic [2:0] k);
      bit a;
      cmd_valid = 1'b1;
      cmd_kind  = k;
      do step(a); while (!a);
      cmd_valid = 1'b0;
      cmd_kind  = 3'd0;
   endtask

   task automatic wr_reg(input logic [31:0] v);
      bit a;
      cfg_we = 1'b1;
      cfg_wdata = v;
      step(a);
      cfg_we = 1'b0;
   endtask

   task automatic prog_pulse();
      bit a;
      cfg_prog = 1'b1;
      step(a);
      cfg_prog = 1'b0;
      step(a);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog all requirements actual=timeout expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      bit hold;
      bit a;
      void'($urandom(32'd2718));
      cyc = 0; d_rc = 0; d_ras = 0; d_rp = 0; d_rcd = 0;
      cl_m = 2; err_m = 0; prog_prev = 0;
      reg_m = 32'h2A73_3225; exp_out = 3'd0; exp_pulse = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset readback
      #1;
      chk(cfg_rdata == 32'h2A73_3225, "R1 reset value", cfg_rdata, 32'h2A73_3225);
      chk(out_cmd == 3'd0, "R9 reset out_cmd", 32'(out_cmd), 32'd0);
      @(negedge clk);

      // R2 R3 R4 R5 with reset timing
      issue(3'd1); issue(3'd2); issue(3'd3); issue(3'd4);
      issue(3'd1); issue(3'd4); issue(3'd5); issue(3'd5); issue(3'd1);
      // R9: NOP and codes 6/7 pass at once
      issue(3'd0); issue(3'd6); issue(3'd7);
      idle(10);

      // R6: latency 5 written but not committed, read still uses 2
      wr_reg(32'h5A73_3225);
      issue(3'd1); issue(3'd2); idle(8);
      prog_pulse();
      issue(3'd2); idle(8);
      // R7: back-to-back reads overlap
      issue(3'd2); issue(3'd2); issue(3'd2); idle(10);

      // R1: reserved bits read zero
      wr_reg(32'hFFFF_FFFF);
      idle(2);

      // R8: reserved codes stretch intervals and set the sticky flag
      wr_reg(32'h2000_0000);
      issue(3'd1); issue(3'd4); issue(3'd1); issue(3'd2);
      issue(3'd5); issue(3'd5); idle(3);
      wr_reg(32'h0A73_3225);
      prog_pulse();
      issue(3'd2); idle(10);
      wr_reg(32'h2A73_3225);
      prog_pulse();

      // constrained random phase
      hold = 0;
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] v;
         if (!hold) begin
            cmd_valid = ($urandom % 4) != 0;
            cmd_kind  = 3'($urandom % 8);
         end
         cfg_we = 1'b0;
         if ($urandom % 60 == 0) begin
            v = $urandom;
            if ($urandom % 8 != 0) begin
               if (v[27:24] == 0) v[24] = 1'b1;
               if (v[23:20] == 0) v[20] = 1'b1;
               if (v[18:16] == 0) v[16] = 1'b1;
               if (v[14:12] == 0) v[12] = 1'b1;
               if (v[30:28] < 2) v[29] = 1'b1;
            end
            cfg_we = 1'b1;
            cfg_wdata = v;
         end
         if ($urandom % 25 == 0) cfg_prog = ~cfg_prog;
         step(a);
         hold = cmd_valid && !a;
      end
      cmd_valid = 1'b0; cfg_we = 1'b0;
      idle(12);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule